// File: doc/BRIEF.md
# Cyclic Eight-Sample DAC Pattern Generator

This block sits in front of a two-channel DAC and can stand in for the normal transmit data path. Each channel owns eight programmable 12-bit sample slots. Software fills these slots through a byte-wide register write port. A run bit for each channel, held in a configuration register, picks what that channel's DAC port carries. When the bit is set, the channel plays its eight stored samples in slot order and repeats them without end. When the bit is clear, the live transmit word passes through.

Both channels run from one DAC sample clock, and each is switched on or off independently of the other. A channel that is switched on always begins with slot 0. A slot may be rewritten while its channel is playing, and the new value comes out the next time the sequence reaches that slot. This makes the block a simple source of known, periodic test tones for bring-up and diagnosis of the analog path.

Top module: `dac_loop_pattern_gen`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after it, both DAC outputs read 0, both run bits are clear and every sample slot holds 0.
- R2: A channel whose run bit is clear drives its DAC output with the transmit word sampled at the previous clock edge, so pass-through has one cycle of latency.
- R3: Slot i (0 to 7) of channel A takes bits [7:0] from a write to address 0x11F+2i and bits [11:8] from a write to address 0x120+2i. Channel B uses the same layout starting at base 0x12F, covering 0x12F to 0x13E.
- R4: For a write to the upper byte of a slot, only `wr_data[3:0]` is stored, and `wr_data[7:4]` is ignored.
- R5: A write to address 0x104 sets the channel A run bit from `wr_data[0]` and the channel B run bit from `wr_data[1]`. Each channel follows only its own bit.
- R6: While a channel's run bit is set, each clock edge outputs the slot at the current index and then advances the index by one, wrapping from 7 to 0.
- R7: When a run bit goes from clear to set, the first pattern edge outputs slot 0. Clearing the bit returns the channel to pass-through at the next edge.
- R8: A slot written while its channel is playing shows its old value at the write edge itself and its new value on the next pass through that slot.
- R9: Writes to addresses outside 0x104 and 0x11F to 0x13E change neither slots nor run bits. Bits [7:2] written to 0x104 have no effect.
- R10: With `wr_en` low, address and data inputs have no effect on any slot or run bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DAC sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register byte address |
| wr_data | input | 8 | Register write data |
| tx_a_in | input | 12 | Live transmit word, channel A |
| tx_b_in | input | 12 | Live transmit word, channel B |
| dac_a_out | output | 12 | DAC sample, channel A |
| dac_b_out | output | 12 | DAC sample, channel B |

## Verification
A wrong index or a corrupted slot shows at the DAC port at the very next clock edge, as a sample out of its expected place in the period-8 sequence. A wrong run bit shows on the same edge, as pass-through data appearing where a pattern is expected, or the reverse. The bench compares every cycle of both channels against a model driven only by the write stream and the live inputs. Because of this, an error in slot storage, address decoding or index wrap is caught within one pattern period (eight cycles) of the cycle in which it is first exercised.

// File: rtl/dac_loop_pattern_gen.sv
module dac_loop_pattern_gen #(
  parameter int DATA_W = 12,
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8,
  parameter logic [8:0] CFG_ADDR  = 9'h104,
  parameter logic [8:0] SLOT_BASE = 9'h11F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [DATA_W-1:0] tx_a_in,
  input  logic [DATA_W-1:0] tx_b_in,
  output logic [DATA_W-1:0] dac_a_out,
  output logic [DATA_W-1:0] dac_b_out
);
  localparam int NCH   = 2;
  localparam int IDX_W = $clog2(SLOTS);
  localparam int SPAN  = 2 * SLOTS;
  localparam int HI_W  = DATA_W - BYTE_W;

  logic [NCH-1:0]                          run;
  logic [NCH-1:0][SLOTS-1:0][DATA_W-1:0]   slot_q;
  logic [NCH-1:0][IDX_W-1:0]               idx_q;
  logic [NCH-1:0][DATA_W-1:0]              live;
  logic [NCH-1:0][DATA_W-1:0]              out_q;

  assign live      = {tx_b_in, tx_a_in};
  assign dac_a_out = out_q[0];
  assign dac_b_out = out_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      run <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CFG_ADDR))
      run <= wr_data[NCH-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_BASE = ADDR_W'(SLOT_BASE) + ADDR_W'(ch * SPAN);

    logic [ADDR_W-1:0] ofs;
    logic              hit;
    logic [IDX_W-1:0]  sel;

    assign ofs = wr_addr - CH_BASE;
    assign hit = wr_en && (ofs < ADDR_W'(SPAN));
    assign sel = ofs[IDX_W:1];

    always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (!rst_n)
          slot_q[ch][s] <= '0;
        else if (hit && sel == IDX_W'(s)) begin
          if (ofs[0])
            slot_q[ch][s][DATA_W-1:BYTE_W] <= wr_data[HI_W-1:0];
          else
            slot_q[ch][s][BYTE_W-1:0] <= wr_data;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !run[ch])
        idx_q[ch] <= '0;
      else
        idx_q[ch] <= (idx_q[ch] == IDX_W'(SLOTS - 1)) ? '0 : idx_q[ch] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        out_q[ch] <= '0;
      else
        out_q[ch] <= run[ch] ? slot_q[ch][idx_q[ch]] : live[ch];
    end
  end
endmodule

// File: rtl/dac_loop_pattern_gen_chk.sv
module dac_loop_pattern_gen_chk #(
  parameter int DATA_W = 12,
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 9,
  parameter logic [8:0] CFG_ADDR = 9'h104
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                wr_en,
  input logic [ADDR_W-1:0]                   wr_addr,
  input logic [DATA_W-1:0]                   tx_a_in,
  input logic [DATA_W-1:0]                   tx_b_in,
  input logic [DATA_W-1:0]                   dac_a_out,
  input logic [DATA_W-1:0]                   dac_b_out,
  input logic [1:0]                          run,
  input logic [1:0][$clog2(SLOTS)-1:0]       idx_q,
  input logic [1:0][SLOTS-1:0][DATA_W-1:0]   slot_q
);
  logic [1:0][DATA_W-1:0] live_w, out_w;
  assign live_w = {tx_b_in, tx_a_in};
  assign out_w  = {dac_b_out, dac_a_out};

  assert_reset_state_R1: assert property (@(posedge clk)
    !$past(rst_n) && rst_n |-> out_w == '0 && run == '0);

  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_en) |-> slot_q == $past(slot_q) && run == $past(run));

  assert_run_only_from_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en) && $past(wr_addr) != ADDR_W'(CFG_ADDR) |-> run == $past(run));

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(run[c]) |-> out_w[c] == $past(live_w[c]));

    assert_pattern_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(run[c]) |-> out_w[c] == $past(slot_q[c][idx_q[c]]));

    assert_start_at_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && run[c] && !$past(run[c]) |-> idx_q[c] == '0);
  end
endmodule

bind dac_loop_pattern_gen dac_loop_pattern_gen_chk #(
  .DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .tx_a_in(tx_a_in), .tx_b_in(tx_b_in),
  .dac_a_out(dac_a_out), .dac_b_out(dac_b_out),
  .run(run), .idx_q(idx_q), .slot_q(slot_q)
);

// File: tb/dac_loop_pattern_gen_bench.sv
module dac_loop_pattern_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] tx_a_in = '0;
  logic [11:0] tx_b_in = '0;
  logic [11:0] dac_a_out, dac_b_out;

  int checks = 0;
  int errors = 0;

  logic [11:0] m_pat [2][8];
  logic        m_run [2];
  int          m_idx [2];
  logic [11:0] txv = 12'h35C;

  localparam int NVEC = 7;
  localparam logic [7:0] CFG_VEC [NVEC] = '{8'h01, 8'h03, 8'h02, 8'h00, 8'hFC, 8'h13, 8'h00};
  localparam int         LEN_VEC [NVEC] = '{11, 13, 9, 4, 5, 17, 3};

  always #2.5 clk = ~clk;

  dac_loop_pattern_gen u_dac_loop_pattern_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_a_in(tx_a_in), .tx_b_in(tx_b_in), .dac_a_out(dac_a_out), .dac_b_out(dac_b_out)
  );

  task automatic check(string tag, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_run[c] = 1'b0;
      m_idx[c] = 0;
      for (int s = 0; s < 8; s++) m_pat[c][s] = '0;
    end
  endtask

  task automatic tick(string tag);
    logic [11:0] exp [2];
    logic [11:0] live [2];
    @(posedge clk);
    live[0] = tx_a_in;
    live[1] = tx_b_in;
    for (int c = 0; c < 2; c++) begin
      exp[c]   = m_run[c] ? m_pat[c][m_idx[c]] : live[c];
      m_idx[c] = m_run[c] ? (m_idx[c] + 1) % 8 : 0;
    end
    if (wr_en) begin
      if (wr_addr == 9'h104) begin
        m_run[0] = wr_data[0];
        m_run[1] = wr_data[1];
      end
      for (int c = 0; c < 2; c++) begin
        int base = 'h11F + 16 * c;
        int a = int'(wr_addr);
        if (a >= base && a < base + 16) begin
          if ((a - base) % 2 == 1) m_pat[c][(a - base) / 2][11:8] = wr_data[3:0];
          else                     m_pat[c][(a - base) / 2][7:0]  = wr_data;
        end
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    txv = txv * 12'd5 + 12'h1A7;
    tx_a_in = txv;
    tx_b_in = ~txv ^ 12'h0F3;
    check(tag, "channel A", dac_a_out, exp[0]);
    check(tag, "channel B", dac_b_out, exp[1]);
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d, string tag);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", "reset A", dac_a_out, 12'h000);
    check("R1", "reset B", dac_b_out, 12'h000);
    rst_n = 1'b1;
    tick("R1");
    tick("R2");

    // R3 / R4: load both channels, upper data nibble carries junk
    for (int i = 0; i < 8; i++) begin
      logic [11:0] pa = 12'h0F0 + 12'h101 * 12'(i);
      logic [11:0] pb = 12'hFFF - 12'h123 * 12'(i);
      wr(9'(9'h11F + 2 * i), pa[7:0], "R3");
      wr(9'(9'h120 + 2 * i), {4'hA, pa[11:8]}, "R4");
      wr(9'(9'h12F + 2 * i), pb[7:0], "R3");
      wr(9'(9'h130 + 2 * i), {4'h5, pb[11:8]}, "R4");
    end

    // R10: strobe low with a slot address and a cfg address presented
    wr_addr = 9'h11F; wr_data = 8'h55; tick("R10");
    wr_addr = 9'h104; wr_data = 8'h03; tick("R10");

    // R9: neighbours of the slot windows and of the cfg address
    wr(9'h11E, 8'h77, "R9");
    wr(9'h13F, 8'h77, "R9");
    wr(9'h105, 8'h03, "R9");
    wr(9'h103, 8'h03, "R9");
    tick("R9");

    // R5 / R6 / R7 / R9: walk the configuration table
    for (int v = 0; v < NVEC; v++) begin
      wr(9'h104, CFG_VEC[v], "R5");
      for (int k = 0; k < LEN_VEC[v]; k++) tick("R6");
    end

    // R8: rewrite slots while channel A plays
    wr(9'h104, 8'h01, "R8");
    repeat (3) tick("R8");
    wr(9'h129, 8'h3C, "R8");
    wr(9'h12A, 8'h0E, "R8");
    repeat (4) tick("R8");
    wr(9'h11F, 8'hC3, "R8");
    repeat (12) tick("R8");

    // R7: stop mid-sequence and restart from slot 0
    wr(9'h104, 8'h00, "R7");
    repeat (2) tick("R7");
    wr(9'h104, 8'h02, "R7");
    repeat (5) tick("R7");
    wr(9'h104, 8'h03, "R7");
    repeat (10) tick("R7");

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    model_reset();
    check("R1", "mid-run reset A", dac_a_out, 12'h000);
    check("R1", "mid-run reset B", dac_b_out, 12'h000);
    rst_n = 1'b1;
    tick("R1");
    wr(9'h104, 8'h03, "R1");
    repeat (9) tick("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule